// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Arbiter

This block gathers interrupt requests and decides which one, if any, the CPU should take next. There are three kinds of source. One request cannot be masked. Two debug requests, a breakpoint and a debug-interface request, have a fixed level. The rest are external and peripheral requests whose levels software sets. The block picks the pending request with the highest level and compares that level with the 4-bit mask field from the CPU status register. When the request may be taken, it raises a request to the CPU and supplies two values: the source's vector number and the value the CPU should load into its mask field.

The block has 17 levels but the mask has only 4 bits. The non-maskable source sits alone at level 16 and is always taken. When it is taken, the new mask value is 15. Every other request is taken only when its level is strictly above the current mask, so a source programmed to level 0 can never win.

The programmable levels sit in 16-bit priority registers that hold four fields each. Software writes them through a simple write port. The CPU pulses an acknowledge when it takes the request. Saving state and fetching from the vector table are the CPU's job.

Top module: `irq_arbiter`

## Requirements
- R1: A rising edge on `nmi_i` produces `irq_o`=1, `irq_vec_o`=11 and `irq_mask_o`=15 whatever `mask_i` holds, including mask 15. It takes precedence over every other request.
- R2: A non-maskable request stays pending until `ack_i` is high in a cycle where `irq_o`=1 and `irq_vec_o`=11. After that, holding `nmi_i` high does not raise it again; only a new rising edge does.
- R3: The breakpoint request `brk_req_i` has fixed level 15. It is taken when `mask_i` < 15 and is blocked when `mask_i` = 15. When taken, it gives vector 12 and new mask 15.
- R4: The debug-interface request `dbg_req_i` has fixed level 15 and gives vector 13. When it ties with the breakpoint request, the breakpoint wins.
- R5: A programmable source is taken only when its level is strictly greater than `mask_i`. The new mask output then equals that level.
- R6: Among pending requests the highest level wins. Among equal levels the lowest index wins, in this order: non-maskable, breakpoint, debug, then source 0 upward.
- R7: A source at level 0 is never taken. When nothing is taken, `irq_o`, `irq_vec_o` and `irq_mask_o` are all 0.
- R8: Priority register k holds the levels of sources 4k to 4k+3. Source 4k+j uses bits [4j+3:4j]. All fields reset to 0. A write to an address at or beyond the number of registers changes nothing.
- R9: Programmable source i gives vector 64+i.
- R10: The outputs are registered. They reflect the inputs of the previous clock edge, and they are 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable request, edge detected |
| brk_req_i | input | 1 | Breakpoint request, level sensitive |
| dbg_req_i | input | 1 | Debug-interface request, level sensitive |
| src_req_i | input | NUM_SRC | Programmable source requests, level sensitive |
| mask_i | input | 4 | Current CPU mask level |
| ack_i | input | 1 | CPU acknowledge of the presented request |
| cfg_we_i | input | 1 | Priority register write strobe |
| cfg_addr_i | input | CFG_AW | Priority register index |
| cfg_wdata_i | input | 16 | Priority register write data |
| irq_o | output | 1 | Request to the CPU |
| irq_vec_o | output | 8 | Vector number of the winning source |
| irq_mask_o | output | 4 | New mask value to load |

## Verification
A wrong internal state would show up at the ports one clock edge later. A stale or lost non-maskable pending bit appears as vector 11 that either stays after the acknowledge or never shows up after an edge. A misplaced priority field shows as the wrong vector, or a wrong new mask value, for a source the bench has programmed to a known level. The tests check each state-holding element through the next output cycle after the stimulus that should change it, or that should leave it alone.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int MASK_W       = 4;
    localparam int LVL_W        = 5;
    localparam int VEC_W        = 8;
    localparam int CFG_DW       = 16;
    localparam int FLD_PER_REG  = CFG_DW / MASK_W;
    localparam int NUM_FIXED    = 3;
    localparam int NMI_VEC      = 11;
    localparam int BRK_VEC      = 12;
    localparam int DBG_VEC      = 13;
    localparam int SRC_VEC_BASE = 64;
    localparam int NMI_LVL      = 16;
    localparam int DBG_FIX_LVL  = 15;

    typedef struct packed {
        logic              irq;
        logic [VEC_W-1:0]  vec;
        logic [MASK_W-1:0] mask;
    } grant_t;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int CFG_AW  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [CFG_AW-1:0]         addr_i,
    input  logic [CFG_DW-1:0]         wdata_i,
    output logic [NUM_SRC*MASK_W-1:0] prio_o
);
    localparam int NUM_REGS = (NUM_SRC + FLD_PER_REG - 1) / FLD_PER_REG;

    logic [CFG_DW-1:0] regs_d [NUM_REGS];
    logic [CFG_DW-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            regs_d[r] = regs_q[r];
            if (we_i && (int'(addr_i) == r)) begin
                regs_d[r] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
        end else begin
            for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= regs_d[r];
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_fld
        assign prio_o[s*MASK_W +: MASK_W] =
            regs_q[s / FLD_PER_REG][(s % FLD_PER_REG)*MASK_W +: MASK_W];
    end
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic clr_i,
    output logic pend_live_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_st_t;

    nmi_st_t st_d, st_q;

    always_comb begin
        st_d.prev = nmi_i;
        st_d.pend = (st_q.pend && !clr_i) || (nmi_i && !st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_live_o = st_d.pend;
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                      nmi_i,
    input  logic                      brk_i,
    input  logic                      dbg_i,
    input  logic [NUM_SRC-1:0]        src_i,
    input  logic [NUM_SRC*MASK_W-1:0] prio_i,
    input  logic [MASK_W-1:0]         mask_i,
    output grant_t                    grant_o
);
    localparam int NCAND = NUM_SRC + NUM_FIXED;

    logic [NCAND-1:0] cand_req;
    logic [LVL_W-1:0] cand_lvl [NCAND];
    logic [VEC_W-1:0] cand_vec [NCAND];

    always_comb begin
        cand_req[0] = nmi_i;
        cand_lvl[0] = LVL_W'(NMI_LVL);
        cand_vec[0] = VEC_W'(NMI_VEC);
        cand_req[1] = brk_i;
        cand_lvl[1] = LVL_W'(DBG_FIX_LVL);
        cand_vec[1] = VEC_W'(BRK_VEC);
        cand_req[2] = dbg_i;
        cand_lvl[2] = LVL_W'(DBG_FIX_LVL);
        cand_vec[2] = VEC_W'(DBG_VEC);
        for (int s = 0; s < NUM_SRC; s++) begin
            cand_req[NUM_FIXED+s] = src_i[s];
            cand_lvl[NUM_FIXED+s] = {1'b0, prio_i[s*MASK_W +: MASK_W]};
            cand_vec[NUM_FIXED+s] = VEC_W'(SRC_VEC_BASE + s);
        end
    end

    logic             found;
    logic [LVL_W-1:0] best_lvl;
    logic [VEC_W-1:0] best_vec;
    logic             best_nmi;
    logic             take;

    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        best_vec = '0;
        best_nmi = 1'b0;
        for (int k = 0; k < NCAND; k++) begin
            if (cand_req[k] && (!found || (cand_lvl[k] > best_lvl))) begin
                found    = 1'b1;
                best_lvl = cand_lvl[k];
                best_vec = cand_vec[k];
                best_nmi = (k == 0);
            end
        end
        take = found && (best_nmi || (best_lvl > {1'b0, mask_i}));

        grant_o = '0;
        if (take) begin
            grant_o.irq  = 1'b1;
            grant_o.vec  = best_vec;
            grant_o.mask = best_nmi ? {MASK_W{1'b1}} : best_lvl[MASK_W-1:0];
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int CFG_AW  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nmi_i,
    input  logic                 brk_req_i,
    input  logic                 dbg_req_i,
    input  logic [NUM_SRC-1:0]   src_req_i,
    input  logic [3:0]           mask_i,
    input  logic                 ack_i,
    input  logic                 cfg_we_i,
    input  logic [CFG_AW-1:0]    cfg_addr_i,
    input  logic [15:0]          cfg_wdata_i,
    output logic                 irq_o,
    output logic [7:0]           irq_vec_o,
    output logic [3:0]           irq_mask_o
);
    logic [NUM_SRC*MASK_W-1:0] prio;
    logic                      nmi_live;
    logic                      nmi_clr;
    grant_t                    out_d, out_q;

    assign nmi_clr = ack_i && out_q.irq && (out_q.vec == VEC_W'(NMI_VEC));

    irq_prio_regs #(.NUM_SRC(NUM_SRC), .CFG_AW(CFG_AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .prio_o  (prio)
    );

    irq_nmi_edge u_nmi (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_i       (nmi_i),
        .clr_i       (nmi_clr),
        .pend_live_o (nmi_live)
    );

    irq_select #(.NUM_SRC(NUM_SRC)) u_sel (
        .nmi_i   (nmi_live),
        .brk_i   (brk_req_i),
        .dbg_i   (dbg_req_i),
        .src_i   (src_req_i),
        .prio_i  (prio),
        .mask_i  (mask_i),
        .grant_o (out_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_o      = out_q.irq;
    assign irq_vec_o  = out_q.vec;
    assign irq_mask_o = out_q.mask;
endmodule

// File: rtl/irq_arbiter_checker.sv
module irq_arbiter_checker #(
    parameter int NUM_SRC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       nmi_i,
    input logic [3:0] mask_i,
    input logic       irq_o,
    input logic [7:0] irq_vec_o,
    input logic [3:0] irq_mask_o
);
    // R1: non-maskable grant always loads mask 15
    a_r1_nmi_mask_f: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && irq_vec_o == 8'd11) |-> (irq_mask_o == 4'hF));

    // R1: an edge on the non-maskable input is presented next cycle
    a_r1_nmi_edge_taken: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_i) |=> (irq_o && irq_vec_o == 8'd11));

    // R5: maskable grants lie strictly above the mask seen at the previous edge
    a_r5_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && irq_vec_o != 8'd11) |-> (irq_mask_o > $past(mask_i)));

    // R7: no grant at level 0, idle outputs are zero
    a_r7_no_zero_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_mask_o != 4'd0));
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_vec_o == 8'd0 && irq_mask_o == 4'd0));

    // R9: only legal vector numbers are presented
    a_r9_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((irq_vec_o >= 8'd11 && irq_vec_o <= 8'd13) ||
                   (int'(irq_vec_o) >= 64 && int'(irq_vec_o) < 64 + NUM_SRC)));
endmodule

bind irq_arbiter irq_arbiter_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_i      (nmi_i),
    .mask_i     (mask_i),
    .irq_o      (irq_o),
    .irq_vec_o  (irq_vec_o),
    .irq_mask_o (irq_mask_o)
);

// File: tb/irq_arbiter_bench.sv
`timescale 1ns/1ps
module irq_arbiter_bench;
    localparam int NSRC = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            nmi = 1'b0, brk = 1'b0, dbg = 1'b0, ack = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic [3:0]      mask = '0;
    logic            we = 1'b0;
    logic [1:0]      addr = '0;
    logic [15:0]     wdata = '0;
    logic            irq;
    logic [7:0]      vec;
    logic [3:0]      nmask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic       irq;
        logic [7:0] vec;
        logic [3:0] mask;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    irq_arbiter #(.NUM_SRC(NSRC), .CFG_AW(2)) u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .brk_req_i(brk), .dbg_req_i(dbg),
        .src_req_i(src), .mask_i(mask), .ack_i(ack), .cfg_we_i(we),
        .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .irq_o(irq), .irq_vec_o(vec), .irq_mask_o(nmask)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (irq !== e.irq || vec !== e.vec || nmask !== e.mask) begin
            errors++;
            $display("FAIL %s: got irq=%0b vec=%0d mask=%0d, expected irq=%0b vec=%0d mask=%0d",
                     e.req, irq, vec, nmask, e.irq, e.vec, e.mask);
        end
    endtask

    // monitor: one scoreboard item per clock edge, sampled after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() != 0) compare(sb.pop_front());
    end

    // driver: set inputs at the falling edge and queue the expected result
    task automatic drive(input logic n, input logic b, input logic d,
                         input logic [NSRC-1:0] s, input logic [3:0] m, input logic a,
                         input logic ei, input logic [7:0] ev, input logic [3:0] em,
                         input string req);
        exp_t e;
        @(negedge clk);
        nmi = n; brk = b; dbg = d; src = s; mask = m; ack = a; we = 1'b0;
        e.irq = ei; e.vec = ev; e.mask = em; e.req = req;
        sb.push_back(e);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] dat);
        @(negedge clk);
        nmi = 1'b0; brk = 1'b0; dbg = 1'b0; src = '0; ack = 1'b0;
        we = 1'b1; addr = a; wdata = dat;
        @(negedge clk);
        we = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(posedge clk);
        #1;
        e.irq = 0; e.vec = 0; e.mask = 0; e.req = "R10 reset";
        compare(e);
        @(negedge clk); rst_n = 1'b1;

        // R7/R8: fields reset to 0, so no source wins
        drive(0,0,0,8'hFF,4'd0,0, 0,8'd0,4'd0, "R7 R8 reset levels zero");

        // R8: src0=3 src1=7 src2=7 src3=0 ; src4=15 src5=1 src6=9 src7=15
        cfg_write(2'd0, 16'h0773);
        cfg_write(2'd1, 16'hF91F);

        drive(0,0,0,8'h01,4'd2,0, 1,8'd64,4'd3, "R5 R9 src0 above mask");
        drive(0,0,0,8'h01,4'd3,0, 0,8'd0,4'd0,  "R5 strict equal mask blocked");
        drive(0,0,0,8'h06,4'd0,0, 1,8'd65,4'd7, "R6 tie lowest index");
        drive(0,0,0,8'h41,4'd0,0, 1,8'd70,4'd9, "R6 highest level wins");
        drive(0,0,0,8'h90,4'd14,0,1,8'd68,4'd15,"R6 tie at 15");
        drive(0,0,0,8'h90,4'd15,0,0,8'd0,4'd0,  "R5 level 15 under mask 15");
        drive(0,0,0,8'h08,4'd0,0, 0,8'd0,4'd0,  "R7 level zero source");
        drive(0,0,0,8'h20,4'd0,0, 1,8'd69,4'd1, "R8 field src5 bits7:4");

        drive(0,1,0,8'h00,4'd15,0,0,8'd0,4'd0,  "R3 break masked at 15");
        drive(0,1,0,8'h00,4'd14,0,1,8'd12,4'd15,"R3 break taken");
        drive(0,0,1,8'h00,4'd0,0, 1,8'd13,4'd15,"R4 debug taken");
        drive(0,1,1,8'h00,4'd0,0, 1,8'd12,4'd15,"R4 break beats debug");
        drive(0,0,1,8'h80,4'd0,0, 1,8'd13,4'd15,"R4 debug beats src7 tie");

        // R8: write beyond register count ignored
        cfg_write(2'd3, 16'h0000);
        drive(0,0,0,8'h01,4'd0,0, 1,8'd64,4'd3, "R8 out of range write ignored");
        cfg_write(2'd0, 16'h5773);
        drive(0,0,0,8'h08,4'd0,0, 1,8'd67,4'd5, "R8 field src3 bits15:12");

        // R1/R2 non-maskable
        drive(1,1,0,8'h80,4'd15,0,1,8'd11,4'd15,"R1 nmi with mask 15");
        drive(1,0,0,8'h00,4'd0,0, 1,8'd11,4'd15,"R2 nmi held pending");
        drive(1,0,0,8'h00,4'd0,1, 0,8'd0,4'd0,  "R2 nmi cleared by ack");
        drive(1,0,0,8'h00,4'd0,0, 0,8'd0,4'd0,  "R2 level high no retrigger");
        drive(1,0,0,8'h04,4'd0,0, 1,8'd66,4'd7, "R2 source after nmi cleared");
        drive(0,0,0,8'h00,4'd0,0, 0,8'd0,4'd0,  "R2 nmi low idle");
        drive(1,0,1,8'h00,4'd3,0, 1,8'd11,4'd15,"R1 new edge beats debug");
        drive(0,0,0,8'h00,4'd0,1, 0,8'd0,4'd0,  "R2 ack after release");

        @(negedge clk);
        src = '0; nmi = 0; ack = 0;
        repeat (3) @(posedge clk);
        #1;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule